// File: doc/BRIEF.md
# Quadrature Encoder to Up/Down Step Translator

This block sits between a hand-turned rotary encoder and a position controller that only understands a step clock, a direction level and an active-low select. It resynchronises the two encoder phases to the system clock and rejects contact bounce on each phase on its own. It then decodes the Gray-coded phase pair into up and down events. Each event becomes one step pulse on a clock-style output that is idle high and acts on its falling edge. A direction level settles before that edge.

Clockwise rotation is the case where phase B changes before phase A. With the phase pair written as {A,B}, clockwise walks 00 → 01 → 11 → 10 → 00 and produces up steps. The reverse walk produces down steps. The rest (detent) state of the encoder is 11. A build-time mode picks between one step for every valid phase change (x4) and one step for every full cycle (x1). A change of both phases at once cannot be decoded, so the block drops it and raises an error pulse. Events that arrive faster than the pulse generator can issue them are held as a signed net count and issued in order of need.

Top module: `qenc_step_xlat`

## Requirements
- R1: While reset is asserted, `step_n_o` is 1, `dir_up_o` is 0, `err_o` is 0 and `sel_n_o` is 1. From the first clock after reset, `sel_n_o` is 0 and stays 0.
- R2: A phase level is accepted only after `FILT_CYCLES` consecutive synchronised samples (default 16) show it. A pulse shorter than that on either phase produces no step and no error.
- R3: A clockwise valid transition ({A,B} moving 00→01→11→10→00) yields steps issued with `dir_up_o` = 1.
- R4: A counter-clockwise valid transition ({A,B} moving 00→10→11→01→00) yields steps issued with `dir_up_o` = 0.
- R5: In mode x4, each valid single-phase transition yields exactly one step.
- R6: In mode x1, a step is issued only when the filtered state enters 11. It is up when 11 is entered along the clockwise order and down when entered along the counter-clockwise order.
- R7: A filtered change of both phases at once yields no step, drives `err_o` high for exactly one cycle, and is adopted as the new reference state.
- R8: `dir_up_o` holds its value for at least `SETUP_CYC` cycles (default 2) before each falling edge of `step_n_o`, and it does not change while `step_n_o` is low.
- R9: `step_n_o` stays low for at least `LOW_CYC` cycles and high for at least `HIGH_CYC` cycles between pulses (defaults 2 and 2).
- R10: Events that arrive while a pulse is in progress are queued as a net signed count of up to `PEND_MAX`, and every queued step is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| step_n_o | output | 1 | Step clock, idle high, one falling edge per step |
| dir_up_o | output | 1 | Direction level: 1 up, 0 down |
| sel_n_o | output | 1 | Active-low select for the controller, low after reset |
| err_o | output | 1 | One-cycle pulse on an undecodable two-phase change |

## Verification
The assertions watch the output timing on every cycle. They cover how long direction stays settled before a falling step edge, that direction does not move while the step is low, the minimum low and high widths of the step, that the select stays low after reset, and that the error pulse lasts one cycle. What a given rotation adds up to can only be shown by the bench's scenarios. That covers the count and direction of steps in both modes, the rejection of pulses shorter than the filter, the handling of two-phase jumps, and no loss of steps in a burst of closely spaced phase changes. The bench checks these totals against a model driven by the same moves.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic {
    MODE_X1 = 1'b0,
    MODE_X4 = 1'b1
  } decode_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_SETUP = 2'd1,
    PS_LOW   = 2'd2,
    PS_HIGH  = 2'd3
  } pace_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } step_evt_t;

  // Position of a {a,b} Gray state along the clockwise order 00,01,11,10
  function automatic logic [1:0] phase_index(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

endpackage

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int   FILT_CYCLES = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic REST_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{REST_LEVEL}};
    end else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // A differing sample must persist FILT_CYCLES times in a row to be taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= REST_LEVEL;
      run_q   <= '0;
    end else if (samp == level_o) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      level_o <= samp;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/qenc_transition_decoder.sv
module qenc_transition_decoder
  import qenc_pkg::*;
#(
  parameter decode_mode_e MODE       = MODE_X4,
  parameter logic [1:0]   REST_STATE = 2'b11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] phase_i,   // {a,b} after filtering
  output step_evt_t evt_o
);
  logic [1:0] prev_q;
  logic [1:0] delta;
  logic       fwd, rev, bad;
  logic       cnt_up, cnt_dn;

  assign delta = phase_index(phase_i[1], phase_i[0]) - phase_index(prev_q[1], prev_q[0]);
  assign fwd   = (delta == 2'd1);
  assign rev   = (delta == 2'd3);
  assign bad   = (delta == 2'd2);

  generate
    if (MODE == MODE_X4) begin : g_x4
      assign cnt_up = fwd;
      assign cnt_dn = rev;
    end else begin : g_x1
      assign cnt_up = fwd && (phase_i == REST_STATE);
      assign cnt_dn = rev && (phase_i == REST_STATE);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= REST_STATE;
      evt_o  <= '0;
    end else begin
      prev_q    <= phase_i;
      evt_o.up  <= cnt_up;
      evt_o.dn  <= cnt_dn;
      evt_o.err <= bad;
    end
  end
endmodule

// File: rtl/qenc_step_pacer.sv
module qenc_step_pacer
  import qenc_pkg::*;
#(
  parameter int PEND_MAX  = 7,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 2,
  parameter int HIGH_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  output logic step_n_o,
  output logic dir_up_o
);
  localparam int PW   = $clog2(PEND_MAX + 1) + 1;
  localparam int TM1  = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int TMAX = (TM1 > HIGH_CYC) ? TM1 : HIGH_CYC;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LOW_LD   = TW'(LOW_CYC - 1);
  localparam logic [TW-1:0] HIGH_LD  = TW'(HIGH_CYC - 1);

  pace_state_e           st_q;
  logic signed [PW-1:0]  pend_q, pend_nxt;
  logic [TW-1:0]         tmr_q;
  logic                  take;
  int                    sum;

  assign take = (st_q == PS_IDLE) && (pend_q != '0);

  // Net signed backlog: arrivals add, a started pulse removes one
  always_comb begin
    sum = int'(pend_q);
    if (up_i) sum = sum + 1;
    if (dn_i) sum = sum - 1;
    if (take) begin
      if (pend_q[PW-1]) sum = sum + 1;
      else              sum = sum - 1;
    end
    if (sum > PEND_MAX)  sum = PEND_MAX;
    if (sum < -PEND_MAX) sum = -PEND_MAX;
    pend_nxt = PW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_IDLE;
      pend_q   <= '0;
      tmr_q    <= '0;
      step_n_o <= 1'b1;
      dir_up_o <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      case (st_q)
        PS_IDLE: begin
          if (take) begin
            dir_up_o <= ~pend_q[PW-1];
            tmr_q    <= SETUP_LD;
            st_q     <= PS_SETUP;
          end
        end
        PS_SETUP: begin
          if (tmr_q == '0) begin
            step_n_o <= 1'b0;
            tmr_q    <= LOW_LD;
            st_q     <= PS_LOW;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        PS_LOW: begin
          if (tmr_q == '0) begin
            step_n_o <= 1'b1;
            tmr_q    <= HIGH_LD;
            st_q     <= PS_HIGH;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        PS_HIGH: begin
          if (tmr_q == '0) st_q <= PS_IDLE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qenc_step_xlat.sv
module qenc_step_xlat
  import qenc_pkg::*;
#(
  parameter int           FILT_CYCLES = 16,
  parameter int           SYNC_STAGES = 2,
  parameter decode_mode_e MODE        = MODE_X4,
  parameter int           PEND_MAX    = 7,
  parameter int           SETUP_CYC   = 2,
  parameter int           LOW_CYC     = 2,
  parameter int           HIGH_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a_i,
  input  logic enc_b_i,
  output logic step_n_o,
  output logic dir_up_o,
  output logic sel_n_o,
  output logic err_o
);
  localparam int         NPH  = 2;
  localparam logic [1:0] REST = 2'b11;

  logic [NPH-1:0] raw_ph;
  logic [NPH-1:0] filt_ph;
  step_evt_t      evt;
  logic           sel_n_q;

  assign raw_ph = {enc_a_i, enc_b_i};

  generate
    for (genvar gi = 0; gi < NPH; gi++) begin : g_phase
      qenc_glitch_filter #(
        .FILT_CYCLES (FILT_CYCLES),
        .SYNC_STAGES (SYNC_STAGES),
        .REST_LEVEL  (REST[gi])
      ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_ph[gi]),
        .level_o (filt_ph[gi])
      );
    end
  endgenerate

  qenc_transition_decoder #(
    .MODE       (MODE),
    .REST_STATE (REST)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (filt_ph),
    .evt_o   (evt)
  );

  qenc_step_pacer #(
    .PEND_MAX  (PEND_MAX),
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC),
    .HIGH_CYC  (HIGH_CYC)
  ) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_i     (evt.up),
    .dn_i     (evt.dn),
    .step_n_o (step_n_o),
    .dir_up_o (dir_up_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_n_q <= 1'b1;
    else        sel_n_q <= 1'b0;
  end

  assign sel_n_o = sel_n_q;
  assign err_o   = evt.err;
endmodule

// File: rtl/qenc_step_xlat_chk.sv
module qenc_step_xlat_chk #(
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 2,
  parameter int HIGH_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic step_n,
  input logic dir_up,
  input logic sel_n,
  input logic err
);
  logic [7:0] low_len, high_len, dir_age;
  logic       dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len  <= '0;
      high_len <= 8'hFF;
      dir_age  <= 8'hFF;
      dir_q    <= 1'b0;
    end else begin
      dir_q    <= dir_up;
      low_len  <= step_n ? 8'd0 : ((low_len == 8'hFF) ? low_len : low_len + 8'd1);
      high_len <= !step_n ? 8'd0 : ((high_len == 8'hFF) ? high_len : high_len + 8'd1);
      dir_age  <= (dir_up != dir_q) ? 8'd1 : ((dir_age == 8'hFF) ? dir_age : dir_age + 8'd1);
    end
  end

  p_sel_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !sel_n);

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_dir_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_n) |-> (int'(dir_age) >= SETUP_CYC));

  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_n && $past(!step_n)) |-> $stable(dir_up));

  p_low_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_n) |-> (int'(low_len) >= LOW_CYC));

  p_high_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_n) |-> (int'(high_len) >= HIGH_CYC));
endmodule

bind qenc_step_xlat qenc_step_xlat_chk #(
  .SETUP_CYC (SETUP_CYC),
  .LOW_CYC   (LOW_CYC),
  .HIGH_CYC  (HIGH_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step_n (step_n_o),
  .dir_up (dir_up_o),
  .sel_n  (sel_n_o),
  .err    (err_o)
);

// File: tb/sim_qenc_step_xlat.sv
`timescale 1ns/1ps
module sim_qenc_step_xlat;
  localparam int FILT  = 16;
  localparam int HOLD  = FILT + 8;
  localparam int DRAIN = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b1;
  logic enc_b = 1'b1;
  logic step0, dir0, sel0, err0;
  logic step1, dir1, sel1, err1;

  always #2.5 clk = ~clk;

  qenc_step_xlat #(.FILT_CYCLES(FILT), .MODE(qenc_pkg::MODE_X4)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .step_n_o(step0), .dir_up_o(dir0), .sel_n_o(sel0), .err_o(err0));

  qenc_step_xlat #(.FILT_CYCLES(FILT), .MODE(qenc_pkg::MODE_X1)) u1 (
    .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .step_n_o(step1), .dir_up_o(dir1), .sel_n_o(sel1), .err_o(err1));

  int n_checks = 0, n_fail = 0;
  int up0 = 0, dn0 = 0, up1 = 0, dn1 = 0, errs = 0;
  int e4_up = 0, e4_dn = 0, e1_up = 0, e1_dn = 0, e_err = 0;
  int pos = 2;
  bit done = 1'b0;

  logic s0_prev = 1'b1, s1_prev = 1'b1, d_prev = 1'b0;
  int low_run = 0, high_run = 0, age = 1000;
  int min_low = 1000, min_high = 1000, min_age = 1000, hold_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dir0 != d_prev) age = 0;
      else if (age < 1000) age++;
      if (!s0_prev && !step0 && dir0 != d_prev) hold_viol++;
      if (s0_prev && !step0) begin
        if (dir0) up0++; else dn0++;
        if (age < min_age) min_age = age;
        if (high_run < min_high) min_high = high_run;
      end
      if (!s0_prev && step0 && low_run < min_low) min_low = low_run;
      if (!step0) begin low_run++; high_run = 0; end
      else begin high_run++; low_run = 0; end
      if (err0) errs++;
      if (s1_prev && !step1) begin
        if (dir1) up1++; else dn1++;
      end
      s0_prev = step0;
      s1_prev = step1;
      d_prev  = dir0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic move_to(input int np, input int hold);
    int d;
    d = (np - pos) & 3;
    if (d == 1) begin e4_up++; if (np == 2) e1_up++; end
    else if (d == 3) begin e4_dn++; if (np == 2) e1_dn++; end
    else if (d == 2) e_err++;
    pos = np & 3;
    @(posedge clk); #1;
    {enc_a, enc_b} = ab_of(pos);
    wait_cyc(hold);
  endtask

  task automatic glitch(input bit on_a, input int len);
    @(posedge clk); #1;
    if (on_a) enc_a = ~enc_a; else enc_b = ~enc_b;
    wait_cyc(len);
    #1;
    {enc_a, enc_b} = ab_of(pos);
    wait_cyc(HOLD);
  endtask

  task automatic compare(input string ctx);
    wait_cyc(DRAIN);
    chk(up0 == e4_up, {"R3 R5 x4 up steps ", ctx}, up0, e4_up);
    chk(dn0 == e4_dn, {"R4 R5 x4 down steps ", ctx}, dn0, e4_dn);
    chk(up1 == e1_up, {"R6 x1 up steps ", ctx}, up1, e1_up);
    chk(dn1 == e1_dn, {"R6 x1 down steps ", ctx}, dn1, e1_dn);
    chk(errs == e_err, {"R7 error pulses ", ctx}, errs, e_err);
  endtask

  initial begin
    void'($urandom(32'h0051_7A3D));
    wait_cyc(3);
    @(negedge clk);
    chk(step0 == 1'b1, "R1 step idle in reset", int'(step0), 1);
    chk(dir0 == 1'b0, "R1 dir low in reset", int'(dir0), 0);
    chk(err0 == 1'b0, "R1 err low in reset", int'(err0), 0);
    chk(sel0 == 1'b1, "R1 select high in reset", int'(sel0), 1);
    rst_n = 1'b1;
    wait_cyc(3);
    @(negedge clk);
    chk(sel0 == 1'b0, "R1 select low after reset", int'(sel0), 0);

    // clockwise: two full cycles from the detent
    for (int k = 0; k < 8; k++) move_to(pos + 1, HOLD);
    compare("clockwise");
    chk(up0 == 8, "R5 eight transitions give eight steps", up0, 8);
    chk(up1 == 2, "R6 two cycles give two steps", up1, 2);

    // counter-clockwise: two full cycles
    for (int k = 0; k < 8; k++) move_to(pos - 1, HOLD);
    compare("counter-clockwise");

    // short pulses on either phase must be ignored
    glitch(1'b1, 3);
    glitch(1'b0, 7);
    glitch(1'b1, FILT - 2);
    glitch(1'b0, FILT - 2);
    compare("R2 short pulses");

    // both phases at once: 11 -> 00
    move_to(0, HOLD);
    compare("R7 double change");
    move_to(1, HOLD);
    move_to(2, HOLD);
    compare("R7 after double change");

    // two transitions three cycles apart: must queue
    move_to(3, 3);
    move_to(0, HOLD);
    compare("R10 quick pair");
    move_to(1, 2);
    move_to(2, HOLD);
    compare("R10 quick pair back");

    // constrained random walk with occasional short glitches
    for (int k = 0; k < 160; k++) begin
      if ($urandom_range(9) == 0) glitch($urandom_range(1) == 1, $urandom_range(FILT - 2, 1));
      if ($urandom_range(99) < 55) move_to(pos + 1, HOLD + $urandom_range(12));
      else                          move_to(pos - 1, HOLD + $urandom_range(12));
      if (k % 40 == 39) compare("random walk");
    end
    compare("random walk end");

    chk(min_age >= 2, "R8 direction lead before fall", min_age, 2);
    chk(hold_viol == 0, "R8 direction held while low", hold_viol, 0);
    chk(min_low >= 2, "R9 minimum low width", min_low, 2);
    chk(min_high >= 2, "R9 minimum high width", min_high, 2);
    @(negedge clk);
    chk(sel0 == 1'b0, "R1 select still low", int'(sel0), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule